// File: doc/BRIEF.md
# Interrupt Routing Matrix for Two CPUs

This block steers a large set of peripheral interrupt request lines onto the external interrupt inputs of two CPUs. Every source owns one small steering register per CPU. The register holds the number of the CPU interrupt slot that the source drives. Any number of sources may share a slot, and the slot is asserted while at least one of them is high. A code that names no slot leaves the source disconnected from that CPU, and this is the reset state.

The last few sources are bound to a single CPU. Two go to CPU 0 only and two go to CPU 1 only. Each CPU can therefore reach all shared sources plus its own pinned pair. One slot per CPU carries non-maskable traffic, and a per-CPU blocking bit can silence it. Software configures the matrix through a plain register write/read port. The same port also returns a snapshot of all raw source levels.

The request lines are level signals and the register port is a control port, so no valid/ready handshake appears anywhere. A write completes in the cycle it is presented. A read returns its data one cycle after the address is presented. Back-pressure never applies.

Top module: `irq_route_matrix`

## Requirements
- R1: After reset every steering register reads 31 (disconnected), both NMI blocking bits read 0, and all CPU interrupt outputs are 0.
- R2: A write to address {0, cpu, src[6:0]} (bit 8 = 0, bit 7 = CPU, bits 6:0 = source index) stores wdata[4:0]. A read of that address returns the value in rdata[4:0] one cycle later, with rdata[31:5] zero.
- R3: Slot e of a CPU rises in the clock after any source steered to e on that CPU is high. It stays high while at least one such source is high.
- R4: Steering codes 26 to 31 name no slot. A source holding such a code drives no output of that CPU, yet the code reads back as written.
- R5: Sources 67 and 68 reach only CPU 0, and sources 69 and 70 reach only CPU 1. Writes to their register for the other CPU are dropped, so that register reads 31 and the source never drives that CPU's outputs.
- R6: Address 0x100 (CPU 0) and address 0x101 (CPU 1) hold a blocking bit in bit 0. While the bit is set, slot 14 (the NMI slot) of that CPU stays 0, and its other slots are unaffected.
- R7: Addresses 0x104, 0x105 and 0x106 return raw source levels. Bit b of word w equals source 32*w+b as sampled at the clock edge that loads rdata. Bits 7 to 31 of word 0x106 read 0.
- R8: CPU outputs are registered with one clock of latency. When no source is high in a cycle, every output is 0 in the next cycle.
- R9: A source's steering for CPU 0 and for CPU 1 are independent. One source can drive different slots on the two CPUs at the same time.
- R10: Reads of unused addresses (a source index at or above 71, or an unlisted control offset) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_irq | input | 71 | Raw level interrupt requests from peripherals |
| wr_en | input | 1 | Register write strobe |
| addr | input | 9 | Register address for read and write |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, valid one cycle after addr |
| cpu0_irq | output | 26 | External interrupt slots of CPU 0 |
| cpu1_irq | output | 26 | External interrupt slots of CPU 1 |

## Verification
The hardest case to reach from the ports is a dropped write to a pinned source's register on the wrong CPU. A dropped write leaves nothing visible unless the same source is later raised while the other CPU has been steered somewhere. The stimulus first attempts the forbidden write and reads the register back. It then makes the legal write for the owning CPU and raises the pinned source together with a shared source. The check confirms that only the intended slots light on each CPU. A similar sequence sets one CPU's NMI blocking bit while a single source feeds the NMI slot of both CPUs, so the blocked CPU and the open CPU are compared in the same cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NUM_CPU        = 2;
  localparam int DEF_NUM_SRC    = 71;
  localparam int DEF_NUM_EXT    = 26;
  localparam int DEF_MAP_W      = 5;
  localparam int DEF_NUM_PINNED = 4;
  localparam int DEF_NMI_SLOT   = 14;
  localparam int DEF_ADDR_W     = 9;
  localparam int DEF_DATA_W     = 32;
  // control space offsets (address bit ADDR_W-1 set)
  localparam int CTRL_MASK_OFF  = 0;
  localparam int CTRL_STAT_OFF  = 4;

  // Pinned sources sit at the top of the index range, split evenly
  // between the CPUs in ascending CPU order.
  function automatic bit src_reaches_cpu(int cpu, int idx, int nsrc, int npin);
    int first_pinned;
    first_pinned = nsrc - npin;
    if (idx < first_pinned) return 1'b1;
    return ((idx - first_pinned) / (npin / NUM_CPU)) == cpu;
  endfunction
endpackage

// File: rtl/irq_map_bank.sv
module irq_map_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC    = DEF_NUM_SRC,
  parameter int MAP_W      = DEF_MAP_W,
  parameter int NUM_PINNED = DEF_NUM_PINNED,
  parameter int CPU_ID     = 0,
  parameter int IDX_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [MAP_W-1:0] wr_val,
  output logic [MAP_W-1:0] map_o [NUM_SRC]
);
  localparam logic [MAP_W-1:0] DISCONNECT = '1;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (src_reaches_cpu(CPU_ID, s, NUM_SRC, NUM_PINNED)) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          map_o[s] <= DISCONNECT;
        else if (wr_en && (wr_idx == IDX_W'(s)))
          map_o[s] <= wr_val;
      end
    end else begin : g_tied
      // source belongs to the other CPU: no storage, never connected
      assign map_o[s] = DISCONNECT;
    end
  end
endmodule

// File: rtl/irq_slot_merge.sv
module irq_slot_merge
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC  = DEF_NUM_SRC,
  parameter int NUM_EXT  = DEF_NUM_EXT,
  parameter int MAP_W    = DEF_MAP_W,
  parameter int NMI_SLOT = DEF_NMI_SLOT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [MAP_W-1:0]   map_i [NUM_SRC],
  input  logic               nmi_block_i,
  output logic [NUM_EXT-1:0] irq_o
);
  logic [NUM_EXT-1:0] slot_next;

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_slot
    logic slot_hit;
    always_comb begin
      slot_hit = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (src_i[s] && (map_i[s] == MAP_W'(e))) slot_hit = 1'b1;
      end
    end
    if (e == NMI_SLOT) begin : g_nmi
      assign slot_next[e] = slot_hit & ~nmi_block_i;
    end else begin : g_plain
      assign slot_next[e] = slot_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= slot_next;
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int MAP_W   = DEF_MAP_W,
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int DATA_W  = DEF_DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic [MAP_W-1:0]    map_i [NUM_CPU][NUM_SRC],
  output logic [NUM_CPU-1:0]  map_we_o,
  output logic [ADDR_W-3:0]   map_idx_o,
  output logic [MAP_W-1:0]    map_val_o,
  output logic [NUM_CPU-1:0]  nmi_mask_o,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int IDX_W      = ADDR_W - 2;
  localparam int STAT_WORDS = (NUM_SRC + DATA_W - 1) / DATA_W;
  localparam int PAD_W      = STAT_WORDS * DATA_W;

  logic              is_ctrl;
  logic              cpu_sel;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-2:0] ctrl_off;
  logic [PAD_W-1:0]  src_pad;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wdata_hi;

  assign is_ctrl         = addr[ADDR_W-1];
  assign cpu_sel         = addr[ADDR_W-2];
  assign idx             = addr[IDX_W-1:0];
  assign ctrl_off        = addr[ADDR_W-2:0];
  assign src_pad         = PAD_W'(src_i);
  assign unused_wdata_hi = ^wdata[DATA_W-1:MAP_W];

  assign map_idx_o = idx;
  assign map_val_o = wdata[MAP_W-1:0];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign map_we_o[c] = wr_en && !is_ctrl && (cpu_sel == c[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        nmi_mask_o[c] <= 1'b0;
      else if (wr_en && is_ctrl && (int'(ctrl_off) == CTRL_MASK_OFF + c))
        nmi_mask_o[c] <= wdata[0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (!is_ctrl) begin
      if (int'(idx) < NUM_SRC) rd_next[MAP_W-1:0] = map_i[cpu_sel][idx];
    end else begin
      for (int c = 0; c < NUM_CPU; c++)
        if (int'(ctrl_off) == CTRL_MASK_OFF + c) rd_next[0] = nmi_mask_o[c];
      for (int w = 0; w < STAT_WORDS; w++)
        if (int'(ctrl_off) == CTRL_STAT_OFF + w) rd_next = src_pad[w*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_next;
  end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC    = DEF_NUM_SRC,
  parameter int NUM_EXT    = DEF_NUM_EXT,
  parameter int MAP_W      = DEF_MAP_W,
  parameter int NUM_PINNED = DEF_NUM_PINNED,
  parameter int NMI_SLOT   = DEF_NMI_SLOT,
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int DATA_W     = DEF_DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_EXT-1:0] cpu0_irq,
  output logic [NUM_EXT-1:0] cpu1_irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [MAP_W-1:0]   map_w [NUM_CPU][NUM_SRC];
  logic [NUM_CPU-1:0] map_we;
  logic [NUM_CPU-1:0] nmi_mask;
  logic [IDX_W-1:0]   map_idx;
  logic [MAP_W-1:0]   map_val;
  logic [NUM_EXT-1:0] cpu_irq [NUM_CPU];

  irq_reg_port #(
    .NUM_SRC(NUM_SRC), .MAP_W(MAP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .src_i(src_irq), .map_i(map_w), .map_we_o(map_we), .map_idx_o(map_idx),
    .map_val_o(map_val), .nmi_mask_o(nmi_mask), .rdata_o(rdata)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_map_bank #(
      .NUM_SRC(NUM_SRC), .MAP_W(MAP_W), .NUM_PINNED(NUM_PINNED),
      .CPU_ID(c), .IDX_W(IDX_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(map_we[c]), .wr_idx(map_idx),
      .wr_val(map_val), .map_o(map_w[c])
    );

    irq_slot_merge #(
      .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .MAP_W(MAP_W), .NMI_SLOT(NMI_SLOT)
    ) u_merge (
      .clk(clk), .rst_n(rst_n), .src_i(src_irq), .map_i(map_w[c]),
      .nmi_block_i(nmi_mask[c]), .irq_o(cpu_irq[c])
    );
  end

  assign cpu0_irq = cpu_irq[0];
  assign cpu1_irq = cpu_irq[1];
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC    = DEF_NUM_SRC,
  parameter int NUM_EXT    = DEF_NUM_EXT,
  parameter int NUM_PINNED = DEF_NUM_PINNED,
  parameter int NMI_SLOT   = DEF_NMI_SLOT,
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int DATA_W     = DEF_DATA_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_irq,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  rdata,
  input logic [NUM_EXT-1:0] cpu0_irq,
  input logic [NUM_EXT-1:0] cpu1_irq,
  input logic [NUM_CPU-1:0] nmi_mask
);
  localparam int STAT_WORDS = (NUM_SRC + DATA_W - 1) / DATA_W;
  localparam int LAST_USED  = NUM_SRC - (STAT_WORDS - 1) * DATA_W;
  localparam int FIRST_PIN  = NUM_SRC - NUM_PINNED;
  localparam int HALF_PIN   = NUM_PINNED / NUM_CPU;
  localparam logic [ADDR_W-1:0] STAT_FIRST = {1'b1, (ADDR_W-1)'(CTRL_STAT_OFF)};
  localparam logic [ADDR_W-1:0] STAT_LAST  =
    {1'b1, (ADDR_W-1)'(CTRL_STAT_OFF + STAT_WORDS - 1)};

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_irq == '0) |=> (cpu0_irq == '0 && cpu1_irq == '0));

  assert_nmi_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_mask[0] |=> !cpu0_irq[NMI_SLOT]);

  assert_nmi_blocked_cpu1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_mask[1] |=> !cpu1_irq[NMI_SLOT]);

  assert_stat_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == STAT_FIRST) |=> (rdata == $past(src_irq[DATA_W-1:0])));

  assert_stat_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == STAT_LAST) |=> (rdata[DATA_W-1:LAST_USED] == '0));

  assert_pinned_cpu0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|src_irq[FIRST_PIN+HALF_PIN-1:0]) |=> (cpu0_irq == '0));

  assert_pinned_cpu1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|src_irq[FIRST_PIN-1:0]) && !(|src_irq[NUM_SRC-1:FIRST_PIN+HALF_PIN]))
      |=> (cpu1_irq == '0));
endmodule

bind irq_route_matrix irq_route_chk #(
  .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .NUM_PINNED(NUM_PINNED),
  .NMI_SLOT(NMI_SLOT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .addr(addr), .rdata(rdata),
  .cpu0_irq(cpu0_irq), .cpu1_irq(cpu1_irq), .nmi_mask(nmi_mask)
);

// File: tb/sim_irq_route_matrix.sv
`timescale 1ns/1ps
module sim_irq_route_matrix;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [70:0] src_irq = '0;
  logic        wr_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [25:0] cpu0_irq, cpu1_irq;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int          due;
    int          kind;   // 0 rdata, 1 cpu0_irq, 2 cpu1_irq
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];

  irq_route_matrix u0 (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cpu0_irq(cpu0_irq), .cpu1_irq(cpu1_irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expectations whose cycle has come
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = {6'd0, cpu0_irq};
        default: act = {6'd0, cpu1_irq};
      endcase
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [31:0] e, string tag);
    item_t it;
    it.due = cyc + 1; it.kind = kind; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, logic [31:0] e, string tag);
    @(negedge clk); wr_en = 1'b0; addr = a;
    push(0, e, tag);
  endtask

  task automatic drive_src(logic [70:0] s, logic [25:0] e0, logic [25:0] e1, string tag);
    @(negedge clk); src_irq = s;
    push(1, {6'd0, e0}, tag);
    push(2, {6'd0, e1}, tag);
  endtask

  task automatic set_src(logic [70:0] s);
    @(negedge clk); src_irq = s;
  endtask

  function automatic logic [70:0] bit_of(int i);
    logic [70:0] v;
    v = '0; v[i] = 1'b1;
    return v;
  endfunction

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset defaults
    rd(9'h000, 32'd31, "R1 cpu0 src0 map");
    rd(9'h0C6, 32'd31, "R1 cpu1 src70 map");
    rd(9'h101, 32'd0,  "R1 cpu1 nmi block");
    drive_src('0, '0, '0, "R1 outputs idle");
    // R2 write and read back
    wr(9'h005, 32'hFFFF_FFE3);
    rd(9'h005, 32'd3,  "R2 cpu0 src5 upper bits zero");
    wr(9'h085, 32'd20);
    rd(9'h085, 32'd20, "R2 cpu1 src5");
    wr(9'h00A, 32'd3);
    rd(9'h00A, 32'd3,  "R2 cpu0 src10");
    // R3 / R9 routing and sharing
    drive_src(bit_of(5), 26'd1 << 3, 26'd1 << 20, "R3 R9 src5 both cpus");
    drive_src(bit_of(10), 26'd1 << 3, '0, "R3 src10 shared slot");
    drive_src(bit_of(5) | bit_of(10), 26'd1 << 3, 26'd1 << 20, "R3 two sources one slot");
    drive_src('0, '0, '0, "R8 quiet after drop");
    // R4 disconnect codes
    wr(9'h014, 32'd26);
    rd(9'h014, 32'd26, "R4 code readback");
    drive_src(bit_of(20), '0, '0, "R4 code 26 drives nothing");
    // R5 pinned sources
    wr(9'h045, 32'd2);
    rd(9'h045, 32'd31, "R5 src69 cpu0 write dropped");
    wr(9'h0C5, 32'd2);
    rd(9'h0C5, 32'd2,  "R5 src69 cpu1 stored");
    wr(9'h0C3, 32'd7);
    rd(9'h0C3, 32'd31, "R5 src67 cpu1 write dropped");
    wr(9'h043, 32'd7);
    rd(9'h043, 32'd7,  "R5 src67 cpu0 stored");
    drive_src(bit_of(69) | bit_of(67), 26'd1 << 7, 26'd1 << 2, "R5 pinned routing");
    // R6 NMI blocking
    wr(9'h007, 32'd14);
    wr(9'h087, 32'd14);
    drive_src(bit_of(7), 26'd1 << 14, 26'd1 << 14, "R6 nmi slot open");
    wr(9'h100, 32'd1);
    rd(9'h100, 32'd1, "R6 cpu0 block readback");
    drive_src(bit_of(7), '0, 26'd1 << 14, "R6 cpu0 blocked cpu1 open");
    wr(9'h101, 32'd1);
    drive_src(bit_of(7) | bit_of(5), 26'd1 << 3, 26'd1 << 20, "R6 other slots unaffected");
    wr(9'h100, 32'd0);
    wr(9'h101, 32'd0);
    drive_src(bit_of(7), 26'd1 << 14, 26'd1 << 14, "R6 unblocked");
    // R7 raw status words
    set_src({7'h55, 32'hDEAD_BEEF, 32'h1234_5678});
    rd(9'h104, 32'h1234_5678, "R7 word0");
    rd(9'h105, 32'hDEAD_BEEF, "R7 word1");
    rd(9'h106, 32'h0000_0055, "R7 word2 padding");
    set_src('0);
    // R10 unused addresses
    rd(9'h1FF, 32'd0, "R10 high ctrl offset");
    rd(9'h047, 32'd0, "R10 source index 71");
    rd(9'h102, 32'd0, "R10 gap offset");
    repeat (4) @(negedge clk);
    done = 1;
    report();
  end
endmodule